// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block is a real-time clock core. A tick-enable input at 32.768 kHz drives a prescaler. Once per second the prescaler advances a packed-BCD calendar of seconds, minutes, hours, day, month and a two-digit year. The year runs from 00 to 99, which stands for 2000 to 2099. Hours count in 24-hour form only. A second set of six BCD registers holds an alarm time. The alarm fires only when every one of the six fields equals the current time; no field can be masked.

Software reaches the block through a simple single-cycle byte register bus: a write strobe, an address and write data, with read data returned combinationally. The 32-bit keys travel on the same write data. Every register write is blocked until a two-key sequence opens the bus, and one further write closes it again.

A status register carries several fields: a busy flag covering the prescaler period just before each update, the run state, one-cycle event pulses for second, minute, hour and day changes, and two sticky flags (alarm and power-up) that are cleared by writing one. The block drives two interrupt outputs: a level alarm interrupt and a pulsed once-per-second timer interrupt, each with its own enable.

Top module: `rtc_calendar_core`

## Requirements
- R1: Writes to the time, alarm, control, status and interrupt-enable registers are ignored until 0x83E70B13 is written to key register 0x6C and then 0x95A4F1E0 to key register 0x70. A wrong second key, a wrong or zero first key, or any new first-key write closes writes again; writing 0 to 0x6C closes an open bus.
- R2: After reset the registers read as follows: seconds 0x00 at 0x00, minutes 0x00 at 0x04, hours 0x00 at 0x08, day 0x01 at 0x0C, month 0x01 at 0x10, year 0x00 at 0x14, all six alarm fields at 0x20..0x34 zero, control 0x40 = 0x00 (stopped), interrupt enable 0x48 = 0x00, and status 0x44 = 0x80 (power-up flag, bit 7).
- R3: While control bit 0 is set, the time advances by one second every PRESCALE tick-enable pulses. Status bit 0 (busy) is high during the final tick period before each update. While the bit is clear, or while no ticks arrive, the time holds and busy stays low. Status bit 1 reads back control bit 0.
- R4: Seconds and minutes roll from 0x59 to 0x00 and carry; hours roll from 0x23 to 0x00 and carry.
- R5: The day rolls to 0x01 after 31 days in months 01, 03, 05, 07, 08, 10 and 12, and after 30 days in 04, 06, 09 and 11. In February it rolls after 29 days when the year (as a number) is divisible by 4, and after 28 otherwise. Month 0x12 rolls to 0x01 and carries into the year, and year 0x99 rolls to 0x00.
- R6: Status bit 2 is high for exactly the one clock after each second update. Bits 3, 4 and 5 are high in that same clock when the update changed the minute, the hour or the day.
- R7: Status bit 6 (alarm) is set one clock after an update that leaves all six time fields equal to the six alarm fields, and is not set if any one field differs. Bits 6 and 7 stay set until a status write with a 1 in that bit.
- R8: irq_alarm is high exactly while status bit 6 and interrupt-enable bit 3 are both set. irq_timer is high in the clock when status bit 2 is high and enable bit 2 is set. Writing 0 to the enable register silences both.
- R9: A write to a time register loads the value at once and restarts the prescaler, so the next update happens PRESCALE ticks after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | One-cycle enable per 32.768 kHz oscillator period |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data; bits 7:0 for byte registers, all 32 for keys |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| irq_alarm | output | 1 | Level alarm interrupt |
| irq_timer | output | 1 | Once-per-second timer interrupt pulse |

## Verification
The last time-register write restarts the prescaler at its write edge. With a tick in every clock and PRESCALE of 4, busy is due three edges later and the new time and event bits four edges later. The alarm flag and irq_alarm follow one edge after that, and the event bits fall one edge after the update. The bench counts those edges from the write task and samples every result in the low half of the clock. A sweep over all twelve months and all hundred years loads the last day of each month at 23:59:59 and compares the rolled-over calendar and status against values worked out from month length and year arithmetic.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int NFIELD = 6;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HR   = 2;
  localparam int F_DAY  = 3;
  localparam int F_MON  = 4;
  localparam int F_YR   = 5;

  typedef logic [NFIELD-1:0][7:0] cal_t;

  typedef enum logic [1:0] {LK_CLOSED, LK_ARMED, LK_OPEN} lock_t;

  localparam logic [31:0] UNLOCK_KEY_A = 32'h83E7_0B13;
  localparam logic [31:0] UNLOCK_KEY_B = 32'h95A4_F1E0;

  localparam logic [7:0] ADDR_CTRL = 8'h40;
  localparam logic [7:0] ADDR_STAT = 8'h44;
  localparam logic [7:0] ADDR_IEN  = 8'h48;
  localparam logic [7:0] ADDR_KEYA = 8'h6C;
  localparam logic [7:0] ADDR_KEYB = 8'h70;

  // Advance one packed-BCD byte by one.
  function automatic logic [7:0] bcd_next(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Last day (BCD) of a BCD month in a BCD year 00..99.
  function automatic logic [7:0] month_days(input logic [7:0] mon,
                                            input logic [7:0] yr);
    logic [7:0] ybin;
    ybin = ({4'd0, yr[7:4]} * 8'd10) + {4'd0, yr[3:0]};
    case (mon)
      8'h02:                      return (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRESCALE = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic run,
  input  logic restart,
  output logic step,
  output logic busy
);
  localparam int CNT_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PRESCALE - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_last;

  always_comb begin
    at_last = (cnt_q == CNT_LAST);
    busy    = run && at_last;
    step    = tick_en && run && at_last && !restart;
    cnt_d   = cnt_q;
    if (restart)             cnt_d = '0;
    else if (tick_en && run) cnt_d = at_last ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST);

  generate
    if (PRESCALE > 1) begin : g_restart_chk
      p_restart_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !busy);
    end
  endgenerate

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [NFIELD-1:0] load,
  input  logic [7:0]        load_val,
  output cal_t              now,
  output logic              roll_min,
  output logic              roll_hr,
  output logic              roll_day
);
  cal_t now_q, now_d;
  logic wrap_day, wrap_mon;

  always_comb begin
    roll_min = (now_q[F_SEC] == 8'h59);
    roll_hr  = roll_min && (now_q[F_MIN] == 8'h59);
    roll_day = roll_hr  && (now_q[F_HR]  == 8'h23);
    wrap_day = roll_day && (now_q[F_DAY] >= month_days(now_q[F_MON], now_q[F_YR]));
    wrap_mon = wrap_day && (now_q[F_MON] == 8'h12);

    now_d = now_q;
    if (step) begin
      now_d[F_SEC] = roll_min ? 8'h00 : bcd_next(now_q[F_SEC]);
      if (roll_min) now_d[F_MIN] = roll_hr  ? 8'h00 : bcd_next(now_q[F_MIN]);
      if (roll_hr)  now_d[F_HR]  = roll_day ? 8'h00 : bcd_next(now_q[F_HR]);
      if (roll_day) now_d[F_DAY] = wrap_day ? 8'h01 : bcd_next(now_q[F_DAY]);
      if (wrap_day) now_d[F_MON] = wrap_mon ? 8'h01 : bcd_next(now_q[F_MON]);
      if (wrap_mon) now_d[F_YR]  = (now_q[F_YR] == 8'h99) ? 8'h00
                                                           : bcd_next(now_q[F_YR]);
    end
    for (int i = 0; i < NFIELD; i++) begin
      if (load[i]) now_d[i] = load_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q         <= '0;
      now_q[F_DAY]  <= 8'h01;
      now_q[F_MON]  <= 8'h01;
    end else begin
      now_q <= now_d;
    end
  end

  assign now = now_q;

  p_step_moves_sec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && load == '0) |=> (now_q[F_SEC] != $past(now_q[F_SEC])));

  p_year_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && load == '0 && now_q[F_YR] == 8'h99 && now_q[F_MON] == 8'h12 &&
     now_q[F_DAY] == 8'h31 && now_q[F_HR] == 8'h23 && now_q[F_MIN] == 8'h59 &&
     now_q[F_SEC] == 8'h59) |=> (now_q[F_YR] == 8'h00 && now_q[F_MON] == 8'h01));

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NFIELD-1:0] load,
  input  logic [7:0]        load_val,
  input  cal_t              now,
  output cal_t              alarm,
  output logic              match
);
  cal_t              alm_q, alm_d;
  logic [NFIELD-1:0] field_eq;

  always_comb begin
    alm_d = alm_q;
    for (int i = 0; i < NFIELD; i++) begin
      if (load[i]) alm_d[i] = load_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alm_q <= '0;
    else        alm_q <= alm_d;
  end

  genvar g;
  generate
    for (g = 0; g < NFIELD; g++) begin : g_cmp
      assign field_eq[g] = (alm_q[g] == now[g]);
    end
  endgenerate

  assign match = &field_eq;
  assign alarm = alm_q;

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter int PRESCALE = 32768
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        bus_wen,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        irq_alarm,
  output logic        irq_timer
);
  // Reset synchronizer: asserts at once, releases on the clock.
  logic rst_meta, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sn   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sn   <= rst_meta;
    end
  end

  // Address decode.
  logic [2:0] fld;
  logic       fld_ok, is_time, is_alarm, is_ctrl, is_stat, is_ien, is_keya, is_keyb;
  assign fld      = bus_addr[4:2];
  assign fld_ok   = (bus_addr[1:0] == 2'b00) && (fld < 3'(NFIELD));
  assign is_time  = (bus_addr[7:5] == 3'b000) && fld_ok;
  assign is_alarm = (bus_addr[7:5] == 3'b001) && fld_ok;
  assign is_ctrl  = (bus_addr == ADDR_CTRL);
  assign is_stat  = (bus_addr == ADDR_STAT);
  assign is_ien   = (bus_addr == ADDR_IEN);
  assign is_keya  = (bus_addr == ADDR_KEYA);
  assign is_keyb  = (bus_addr == ADDR_KEYB);

  // State.
  lock_t      lock_q, lock_d;
  logic       run_q, run_d;
  logic       ie_tmr_q, ie_tmr_d, ie_alm_q, ie_alm_d;
  logic       alm_flag_q, alm_flag_d, pwr_q, pwr_d;
  logic [3:0] ev_q, ev_d;
  logic       wr_ok;

  logic [NFIELD-1:0] time_load, alarm_load;
  logic              step, busy, match, roll_min, roll_hr, roll_day;
  cal_t              now, alarm;

  assign wr_ok = bus_wen && (lock_q == LK_OPEN);

  genvar g;
  generate
    for (g = 0; g < NFIELD; g++) begin : g_load
      assign time_load[g]  = wr_ok && is_time  && (fld == 3'(g));
      assign alarm_load[g] = wr_ok && is_alarm && (fld == 3'(g));
    end
  endgenerate

  rtc_prescaler #(.PRESCALE(PRESCALE)) u_presc (
    .clk     (clk),
    .rst_n   (rst_sn),
    .tick_en (tick_en),
    .run     (run_q),
    .restart (|time_load),
    .step    (step),
    .busy    (busy)
  );

  rtc_calendar u_cal (
    .clk      (clk),
    .rst_n    (rst_sn),
    .step     (step),
    .load     (time_load),
    .load_val (bus_wdata[7:0]),
    .now      (now),
    .roll_min (roll_min),
    .roll_hr  (roll_hr),
    .roll_day (roll_day)
  );

  rtc_alarm_match u_alm (
    .clk      (clk),
    .rst_n    (rst_sn),
    .load     (alarm_load),
    .load_val (bus_wdata[7:0]),
    .now      (now),
    .alarm    (alarm),
    .match    (match)
  );

  // Next state.
  always_comb begin
    lock_d = lock_q;
    if (bus_wen && is_keya) begin
      lock_d = (bus_wdata == UNLOCK_KEY_A) ? LK_ARMED : LK_CLOSED;
    end else if (bus_wen && is_keyb && lock_q == LK_ARMED) begin
      lock_d = (bus_wdata == UNLOCK_KEY_B) ? LK_OPEN : LK_CLOSED;
    end

    run_d    = run_q;
    ie_tmr_d = ie_tmr_q;
    ie_alm_d = ie_alm_q;
    if (wr_ok && is_ctrl) run_d = bus_wdata[0];
    if (wr_ok && is_ien) begin
      ie_tmr_d = bus_wdata[2];
      ie_alm_d = bus_wdata[3];
    end

    ev_d = {step && roll_day, step && roll_hr, step && roll_min, step};

    alm_flag_d = alm_flag_q;
    pwr_d      = pwr_q;
    if (wr_ok && is_stat && bus_wdata[6]) alm_flag_d = 1'b0;
    if (wr_ok && is_stat && bus_wdata[7]) pwr_d      = 1'b0;
    if (ev_q[0] && match)                 alm_flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      lock_q     <= LK_CLOSED;
      run_q      <= 1'b0;
      ie_tmr_q   <= 1'b0;
      ie_alm_q   <= 1'b0;
      ev_q       <= '0;
      alm_flag_q <= 1'b0;
      pwr_q      <= 1'b1;
    end else begin
      lock_q     <= lock_d;
      run_q      <= run_d;
      ie_tmr_q   <= ie_tmr_d;
      ie_alm_q   <= ie_alm_d;
      ev_q       <= ev_d;
      alm_flag_q <= alm_flag_d;
      pwr_q      <= pwr_d;
    end
  end

  // Read-back.
  logic [7:0] status;
  assign status = {pwr_q, alm_flag_q, ev_q, run_q, busy};

  always_comb begin
    bus_rdata = 8'h00;
    if (is_time)       bus_rdata = now[fld];
    else if (is_alarm) bus_rdata = alarm[fld];
    else if (is_ctrl)  bus_rdata = {7'd0, run_q};
    else if (is_stat)  bus_rdata = status;
    else if (is_ien)   bus_rdata = {4'd0, ie_alm_q, ie_tmr_q, 2'd0};
  end

  assign irq_alarm = alm_flag_q && ie_alm_q;
  assign irq_timer = ev_q[0] && ie_tmr_q;

  // Checks.
  p_lock_write_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_wen && is_time && lock_q != LK_OPEN && !step) |=> (now == $past(now)));

  p_alarm_set_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (ev_q[0] && match) |=> alm_flag_q);

  p_alarm_hold_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (alm_flag_q && !(wr_ok && is_stat && bus_wdata[6])) |=> alm_flag_q);

  p_pwr_sticky_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    !pwr_q |=> !pwr_q);

  generate
    if (PRESCALE > 1) begin : g_ev_chk
      p_event_pulse_r6: assert property (@(posedge clk) disable iff (!rst_sn)
        ev_q[0] |=> !ev_q[0]);
    end
  endgenerate

endmodule

// File: tb/rtc_calendar_core_tb_top.sv
module rtc_calendar_core_tb_top;
  localparam int PRESCALE = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en;
  logic        bus_wen;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [7:0]  bus_rdata;
  logic        irq_alarm, irq_timer;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rtc_calendar_core #(.PRESCALE(PRESCALE)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wen(bus_wen),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_alarm(irq_alarm), .irq_timer(irq_timer)
  );

  task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called just after a falling edge; the write lands on the next rising edge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wen   = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_wen   = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic read_time(output logic [47:0] t);
    logic [7:0] b;
    for (int i = 5; i >= 0; i--) begin
      rd(8'(i * 4), b);
      t[i*8 +: 8] = b;
    end
  endtask

  task automatic set_time(input logic [47:0] t);
    for (int i = 5; i >= 0; i--) wr(8'(i * 4), {24'd0, t[i*8 +: 8]});
  endtask

  task automatic unlock();
    wr(8'h6C, 32'h83E70B13);
    wr(8'h70, 32'h95A4F1E0);
  endtask

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int dim(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [47:0] t;
    logic [7:0]  b;
    rst_n = 1'b0; tick_en = 1'b1; bus_wen = 1'b0; bus_addr = 8'h00; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 reset state
    read_time(t);  check("R2 time", t, {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00});
    rd(8'h44, b);  check("R2 status", {40'd0, b}, 48'h80);
    rd(8'h40, b);  check("R2 ctrl", {40'd0, b}, 48'h00);
    rd(8'h48, b);  check("R2 ien", {40'd0, b}, 48'h00);
    for (int i = 0; i < 6; i++) begin
      rd(8'(8'h20 + i * 4), b); check("R2 alarm field", {40'd0, b}, 48'h00);
    end
    @(negedge clk);

    // R1 write lock
    wr(8'h00, 32'h33);  rd(8'h00, b); check("R1 locked write", {40'd0, b}, 48'h00);
    wr(8'h44, 32'h80);  rd(8'h44, b); check("R1 locked status clear", {40'd0, b}, 48'h80);
    wr(8'h6C, 32'h83E70B13);
    wr(8'h00, 32'h33);  rd(8'h00, b); check("R1 first key only", {40'd0, b}, 48'h00);
    wr(8'h6C, 32'h83E70B13);
    wr(8'h70, 32'h12345678);
    wr(8'h00, 32'h33);  rd(8'h00, b); check("R1 wrong second key", {40'd0, b}, 48'h00);
    unlock();
    wr(8'h00, 32'h12);  rd(8'h00, b); check("R1 open write", {40'd0, b}, 48'h12);
    wr(8'h6C, 32'h0);
    wr(8'h00, 32'h44);  rd(8'h00, b); check("R1 relocked", {40'd0, b}, 48'h12);
    unlock();

    // R7 power-up flag write-one-clear
    wr(8'h44, 32'h80);  rd(8'h44, b); check("R7 power flag clear", {40'd0, b}, 48'h00);

    // R3 stopped clock holds
    repeat (20) @(negedge clk);
    rd(8'h00, b); check("R3 stopped holds", {40'd0, b}, 48'h12);
    @(negedge clk);
    wr(8'h40, 32'h01);
    rd(8'h44, b); check("R3 run status", {40'd0, b & 8'h02}, 48'h02);
    @(negedge clk);

    // R9/R3/R6 single increment timing
    set_time({8'h24, 8'h06, 8'h10, 8'h08, 8'h30, 8'h05});
    repeat (3) @(negedge clk);
    rd(8'h44, b); check("R9 busy three edges after load", {40'd0, b}, 48'h03);
    rd(8'h00, b); check("R3 not yet advanced", {40'd0, b}, 48'h05);
    @(negedge clk);
    read_time(t); check("R3 advanced", t, {8'h24, 8'h06, 8'h10, 8'h08, 8'h30, 8'h06});
    rd(8'h44, b); check("R6 second event", {40'd0, b}, 48'h06);
    check("R8 timer irq disabled", {47'd0, irq_timer}, 48'h0);
    @(negedge clk);
    rd(8'h44, b); check("R6 event one clock", {40'd0, b}, 48'h02);

    // R3 no ticks, no advance
    set_time({8'h24, 8'h06, 8'h10, 8'h08, 8'h30, 8'h20});
    tick_en = 1'b0;
    repeat (10) @(negedge clk);
    rd(8'h00, b); check("R3 no tick holds", {40'd0, b}, 48'h20);
    rd(8'h44, b); check("R3 no busy without ticks", {40'd0, b}, 48'h02);
    tick_en = 1'b1;
    repeat (4) @(negedge clk);
    rd(8'h00, b); check("R3 advance after ticks", {40'd0, b}, 48'h21);
    @(negedge clk);

    // R4 partial rollovers
    set_time({8'h24, 8'h06, 8'h10, 8'h13, 8'h59, 8'h59});
    repeat (4) @(negedge clk);
    read_time(t); check("R4 hour carry", t, {8'h24, 8'h06, 8'h10, 8'h14, 8'h00, 8'h00});
    rd(8'h44, b); check("R6 min hour events", {40'd0, b}, 48'h1E);
    set_time({8'h24, 8'h06, 8'h10, 8'h00, 8'h00, 8'h59});
    repeat (4) @(negedge clk);
    read_time(t); check("R4 minute carry", t, {8'h24, 8'h06, 8'h10, 8'h00, 8'h01, 8'h00});
    rd(8'h44, b); check("R6 minute event", {40'd0, b}, 48'h0E);

    // R8 timer interrupt
    wr(8'h48, 32'h04);
    set_time({8'h24, 8'h06, 8'h10, 8'h00, 8'h00, 8'h10});
    repeat (4) @(negedge clk);
    check("R8 timer irq pulse", {47'd0, irq_timer}, 48'h1);
    @(negedge clk);
    check("R8 timer irq falls", {47'd0, irq_timer}, 48'h0);

    // R7/R8 alarm
    wr(8'h48, 32'h08);
    wr(8'h34, 32'h24); wr(8'h30, 32'h03); wr(8'h2C, 32'h15);
    wr(8'h28, 32'h10); wr(8'h24, 32'h20); wr(8'h20, 32'h31);
    set_time({8'h24, 8'h03, 8'h15, 8'h10, 8'h20, 8'h30});
    repeat (4) @(negedge clk);
    rd(8'h44, b); check("R7 alarm not before", {40'd0, b}, 48'h06);
    check("R8 irq low before", {47'd0, irq_alarm}, 48'h0);
    @(negedge clk);
    rd(8'h44, b); check("R7 alarm set", {40'd0, b}, 48'h42);
    check("R8 irq alarm", {47'd0, irq_alarm}, 48'h1);
    repeat (6) @(negedge clk);
    check("R8 irq alarm level holds", {47'd0, irq_alarm}, 48'h1);
    wr(8'h44, 32'h40);
    rd(8'h44, b); check("R7 alarm cleared", {40'd0, b & 8'h40}, 48'h0);
    check("R8 irq cleared", {47'd0, irq_alarm}, 48'h0);
    @(negedge clk);

    // R7 one field differs
    wr(8'h34, 32'h25);
    set_time({8'h24, 8'h03, 8'h15, 8'h10, 8'h20, 8'h30});
    repeat (6) @(negedge clk);
    rd(8'h44, b); check("R7 year mismatch no alarm", {40'd0, b & 8'h40}, 48'h0);
    check("R8 no irq on mismatch", {47'd0, irq_alarm}, 48'h0);
    @(negedge clk);

    // R8 enable gating
    wr(8'h48, 32'h00);
    wr(8'h34, 32'h24);
    set_time({8'h24, 8'h03, 8'h15, 8'h10, 8'h20, 8'h30});
    repeat (5) @(negedge clk);
    rd(8'h44, b); check("R7 flag without enable", {40'd0, b & 8'h40}, 48'h40);
    check("R8 irq masked", {47'd0, irq_alarm}, 48'h0);
    wr(8'h48, 32'h08);
    check("R8 irq on enable", {47'd0, irq_alarm}, 48'h1);
    wr(8'h48, 32'h00);
    check("R8 irq off by zero write", {47'd0, irq_alarm}, 48'h0);
    wr(8'h44, 32'h40);
    wr(8'h2C, 32'h00);

    // R5/R6 month and year sweep
    for (int y = 0; y < 100; y++) begin
      for (int m = 1; m <= 12; m++) begin
        int d, nm, ny;
        d  = dim(m, y);
        nm = (m == 12) ? 1 : m + 1;
        ny = (m == 12) ? (y + 1) % 100 : y;
        set_time({bcd(y), bcd(m), bcd(d), 8'h23, 8'h59, 8'h59});
        repeat (4) @(negedge clk);
        read_time(t);
        check("R5 month end rollover", t, {bcd(ny), bcd(nm), 8'h01, 8'h00, 8'h00, 8'h00});
        rd(8'h44, b); check("R6 all events", {40'd0, b}, 48'h3E);
        if (m == 2) begin
          set_time({bcd(y), 8'h02, bcd(d - 1), 8'h23, 8'h59, 8'h59});
          repeat (4) @(negedge clk);
          read_time(t);
          check("R5 february day before end", t, {bcd(y), 8'h02, bcd(d), 8'h00, 8'h00, 8'h00});
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule